// File: doc/BRIEF.md
# Split-Mode Event Counter Bank

This block holds four 32-bit physical event counters behind a single register port with a 64-bit data path. Each counter runs either as one 32-bit counter or as two 16-bit halves that count and wrap on their own. The choice is made by one split bit per counter in a control register. Eight logical counter addresses map onto the four physical counters. Logical index modulo four picks the physical counter. In split mode, logical indices 0 to 3 reach the upper halves and 4 to 7 reach the lower halves.

Software never writes a running counter directly. A counter write goes into a per-counter holding latch and marks that latch pending. The pending value moves into the live counter only when the control register is written with its enable bit set. This is true even if enable was already set. While a latch is pending, a read of that counter returns the latch. Otherwise it returns the live value.

Each counter, or each half in split mode, raises an overflow flag when it wraps from all ones to zero. Writing the status register loads an interrupt mask. Reading it returns the flags and clears them. The interrupt output is high while any flag is both set and enabled by the mask.

Top module: `evtctr_bank`

## Requirements
- R1: After reset the control register, the status flags and all counter reads are zero, and `irq` is low.
- R2: A write to a counter address stores the value in that counter's holding latch and marks it pending. While it is pending, reads of that counter return the latch value, whatever events arrive.
- R3: A control write with bit 31 (enable) set copies every pending latch into its live counter and clears the pending marks. This also happens when enable was already set before the write.
- R4: Counters advance by one per cycle of their strobe only while enable is set. In 32-bit mode, physical counter p counts on `evtStrobe[p]`, ignores `evtStrobe[p+4]`, and carries from bit 15 into bit 16.
- R5: Control bit p selects split mode for physical counter p. In split mode, a read of logical index p returns the upper half and a read of index p+4 returns the lower half, both zero-extended. In 32-bit mode both indices return the full 32-bit value.
- R6: In split mode, a write to a logical index takes its low 16 bits into the selected half only. The other half keeps its current readable value.
- R7: In split mode each half counts on its own strobe (`evtStrobe[p]` for the upper half, `evtStrobe[p+4]` for the lower half) and wraps at 16 bits without carrying into the other half.
- R8: Status flag bit p is set when physical counter p wraps in 32-bit mode or its upper half wraps in split mode. Flag bit p+4 is set when its lower half wraps. A status read returns the flags in register bits 7:0 and clears them.
- R9: A status write loads the interrupt mask from register bits 7:0. `irq` is the OR of the flags that are both set and masked in. Writing zero forces `irq` low.
- R10: Each 32-bit register sits in bits 63:32 of the data bus. Bits 31:0 read as zero and are ignored on write.
- R11: The control register is at address 0 and keeps only bit 31 and bits 3:0, so other bits read as zero. Status is at address 1. Logical counters 0 to 7 are at addresses 8 to 15. Other addresses read as zero. Read data appears with `regRdValid` one cycle after `regRdEn`, and `regRdData` is zero in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 64 | Write data; register value in bits 63:32 |
| regRdData | output | 64 | Read data, one cycle after the read strobe |
| regRdValid | output | 1 | Marks the cycle that carries read data |
| evtStrobe | input | 8 | Per-logical-counter increment strobes |
| irq | output | 1 | Interrupt: OR of the enabled, pending overflow flags |

## Verification
The counters are driven in three ways:
- Single-bit strobes on a 32-bit counter, and strobes on the unused lower-half line in 32-bit mode. These separate true counting from leakage through the ignored strobe, and show that nothing counts while enable is clear.
- Split-mode runs that wrap the lower half and then the upper half of the same counter. These show whether a carry crosses the half boundary and whether the two flags land on the right bits.
- Counter writes made while counting is enabled, followed by strobes and then a control rewrite. These show the hold-in-latch behaviour apart from the commit.

Mask patterns that include and exclude the flag that is set, followed by a zero mask, test the interrupt gating.

// File: rtl/evtctr_pkg.sv
package evtctr_pkg;
  parameter int PHYS_CNT = 4;
  parameter int CTR_W = 32;
  localparam int HALF_W = CTR_W / 2;
  localparam int LOG_CNT = 2 * PHYS_CNT;

  // Strobes from the register control to the counter datapath
  typedef struct packed {
    logic                countEn;
    logic                commit;
    logic [PHYS_CNT-1:0] split;
    logic [PHYS_CNT-1:0] latchWr;
    logic [CTR_W-1:0]    latchData;
  } ctrl_strb_t;
endpackage

// File: rtl/evtctr_slice.sv
module evtctr_slice #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic             split,
  input  logic             evtHi,
  input  logic             evtLo,
  input  logic             latchWr,
  input  logic [CTR_W-1:0] latchData,
  input  logic             commit,
  output logic [CTR_W-1:0] view,
  output logic             ovfHi,
  output logic             ovfLo
);
  localparam int HALF_W = CTR_W / 2;

  logic [CTR_W-1:0] liveQ;
  logic [CTR_W-1:0] liveNext;
  logic [CTR_W-1:0] latchQ;
  logic             pendQ;
  logic             incHi;
  logic             incLo;
  logic             loadNow;

  assign incHi   = countEn & evtHi;
  assign incLo   = countEn & evtLo & split;
  assign loadNow = commit & pendQ;

  always_comb begin
    liveNext = liveQ;
    ovfHi    = 1'b0;
    ovfLo    = 1'b0;
    if (loadNow) begin
      liveNext = latchQ;
    end else if (split) begin
      if (incHi) begin
        liveNext[CTR_W-1:HALF_W] = liveQ[CTR_W-1:HALF_W] + HALF_W'(1);
        ovfHi = &liveQ[CTR_W-1:HALF_W];
      end
      if (incLo) begin
        liveNext[HALF_W-1:0] = liveQ[HALF_W-1:0] + HALF_W'(1);
        ovfLo = &liveQ[HALF_W-1:0];
      end
    end else if (incHi) begin
      liveNext = liveQ + CTR_W'(1);
      ovfHi    = &liveQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveQ  <= '0;
      latchQ <= '0;
      pendQ  <= 1'b0;
    end else begin
      liveQ <= liveNext;
      if (latchWr) begin
        latchQ <= latchData;
        pendQ  <= 1'b1;
      end else if (commit) begin
        pendQ <= 1'b0;
      end
    end
  end

  assign view = pendQ ? latchQ : liveQ;
endmodule

// File: rtl/evtctr_datapath.sv
module evtctr_datapath
  import evtctr_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_strb_t                     strb,
  input  logic [LOG_CNT-1:0]             evt,
  output logic [PHYS_CNT-1:0][CTR_W-1:0] viewVal,
  output logic [LOG_CNT-1:0]             ovf
);
  for (genvar p = 0; p < PHYS_CNT; p++) begin : g_slice
    evtctr_slice #(.CTR_W(CTR_W)) slice_i (
      .clk      (clk),
      .rstN     (rstN),
      .countEn  (strb.countEn),
      .split    (strb.split[p]),
      .evtHi    (evt[p]),
      .evtLo    (evt[p+PHYS_CNT]),
      .latchWr  (strb.latchWr[p]),
      .latchData(strb.latchData),
      .commit   (strb.commit),
      .view     (viewVal[p]),
      .ovfHi    (ovf[p]),
      .ovfLo    (ovf[p+PHYS_CNT])
    );
  end
endmodule

// File: rtl/evtctr_ctrl.sv
module evtctr_ctrl
  import evtctr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int ENABLE_BIT = 31
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic                           regRdEn,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [2*CTR_W-1:0]             regWrData,
  output logic [2*CTR_W-1:0]             regRdData,
  output logic                           regRdValid,
  output logic                           irq,
  input  logic [PHYS_CNT-1:0][CTR_W-1:0] viewVal,
  input  logic [LOG_CNT-1:0]             ovf,
  output ctrl_strb_t                     strb
);
  localparam int REG_W      = CTR_W;
  localparam int LOG_IDX_W  = $clog2(LOG_CNT);
  localparam int PHYS_IDX_W = $clog2(PHYS_CNT);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);

  logic [REG_W-1:0]      wrWord;
  logic [REG_W-1:0]      unusedLowWr;
  logic                  isCtrl;
  logic                  isStat;
  logic                  isCtr;
  logic [LOG_IDX_W-1:0]  logIdx;
  logic [PHYS_IDX_W-1:0] physIdx;
  logic                  isLower;
  logic [CTR_W-1:0]      selVal;
  logic [CTR_W-1:0]      mergeVal;
  logic [REG_W-1:0]      rdWord;

  logic                  enReg;
  logic [PHYS_CNT-1:0]   splitReg;
  logic [LOG_CNT-1:0]    maskReg;
  logic [LOG_CNT-1:0]    flagsQ;

  assign wrWord      = regWrData[2*REG_W-1:REG_W];
  assign unusedLowWr = regWrData[REG_W-1:0];

  assign isCtrl  = (regAddr == ADDR_CTRL);
  assign isStat  = (regAddr == ADDR_STAT);
  assign isCtr   = regAddr[ADDR_W-1];
  assign logIdx  = regAddr[LOG_IDX_W-1:0];
  assign physIdx = logIdx[PHYS_IDX_W-1:0];
  assign isLower = logIdx[PHYS_IDX_W];
  assign selVal  = viewVal[physIdx];

  // Merge a half-width write into the currently readable value
  always_comb begin
    mergeVal = wrWord;
    if (splitReg[physIdx]) begin
      if (isLower) mergeVal = {selVal[CTR_W-1:HALF_W], wrWord[HALF_W-1:0]};
      else         mergeVal = {wrWord[HALF_W-1:0], selVal[HALF_W-1:0]};
    end
  end

  always_comb begin
    strb.countEn   = enReg;
    strb.split     = splitReg;
    strb.commit    = regWrEn & isCtrl & wrWord[ENABLE_BIT];
    strb.latchData = mergeVal;
    for (int p = 0; p < PHYS_CNT; p++) begin
      strb.latchWr[p] = regWrEn & isCtr & (physIdx == PHYS_IDX_W'(p));
    end
  end

  always_comb begin
    rdWord = '0;
    if (isCtrl) begin
      rdWord[ENABLE_BIT]   = enReg;
      rdWord[PHYS_CNT-1:0] = splitReg;
    end else if (isStat) begin
      rdWord[LOG_CNT-1:0] = flagsQ;
    end else if (isCtr) begin
      if (splitReg[physIdx]) begin
        rdWord = isLower ? {{HALF_W{1'b0}}, selVal[HALF_W-1:0]}
                         : {{HALF_W{1'b0}}, selVal[CTR_W-1:HALF_W]};
      end else begin
        rdWord = selVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg      <= 1'b0;
      splitReg   <= '0;
      maskReg    <= '0;
      flagsQ     <= '0;
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      if (regWrEn && isCtrl) begin
        enReg    <= wrWord[ENABLE_BIT];
        splitReg <= wrWord[PHYS_CNT-1:0];
      end
      if (regWrEn && isStat) maskReg <= wrWord[LOG_CNT-1:0];
      if (regRdEn && isStat) flagsQ <= ovf;
      else                   flagsQ <= flagsQ | ovf;
      regRdValid <= regRdEn;
      regRdData  <= regRdEn ? {rdWord, {REG_W{1'b0}}} : '0;
    end
  end

  assign irq = |(flagsQ & maskReg);
endmodule

// File: rtl/evtctr_bank.sv
module evtctr_bank
  import evtctr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int ENABLE_BIT = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [2*CTR_W-1:0] regWrData,
  output logic [2*CTR_W-1:0] regRdData,
  output logic               regRdValid,
  input  logic [LOG_CNT-1:0] evtStrobe,
  output logic               irq
);
  ctrl_strb_t                     ctrlStrb;
  logic [PHYS_CNT-1:0][CTR_W-1:0] viewVal;
  logic [LOG_CNT-1:0]             ovf;

  evtctr_ctrl #(.ADDR_W(ADDR_W), .ENABLE_BIT(ENABLE_BIT)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .regRdValid(regRdValid),
    .irq       (irq),
    .viewVal   (viewVal),
    .ovf       (ovf),
    .strb      (ctrlStrb)
  );

  evtctr_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (ctrlStrb),
    .evt    (evtStrobe),
    .viewVal(viewVal),
    .ovf    (ovf)
  );
endmodule

// File: rtl/evtctr_bank_chk.sv
module evtctr_bank_chk #(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 64,
  parameter int VIEW_W = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [BUS_W-1:0]  regWrData,
  input logic [BUS_W-1:0]  regRdData,
  input logic              regRdValid,
  input logic              irq,
  input logic              countEn,
  input logic [VIEW_W-1:0] viewFlat
);
  localparam int REG_W = BUS_W / 2;

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid);

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdValid |-> (regRdData == '0));

  // R10
  low_half_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdValid |-> (regRdData[REG_W-1:0] == '0));

  // R9
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(1) && regWrData[BUS_W-1:REG_W] == '0) |=> !irq);

  // R4
  count_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !regWrEn) |=> $stable(viewFlat));
endmodule

bind evtctr_bank evtctr_bank_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .regRdValid(regRdValid),
  .irq       (irq),
  .countEn   (ctrlStrb.countEn),
  .viewFlat  (viewVal)
);

// File: tb/evtctr_bank_tb_top.sv
module evtctr_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT_CYC = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        regRdValid;
  logic [7:0]  evtStrobe = '0;
  logic        irq;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  logic [63:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evtctr_bank dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .regRdValid(regRdValid),
    .evtStrobe (evtStrobe),
    .irq       (irq)
  );

  // Monitor: compares read results against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && regRdValid) begin
      checkCnt++;
      if (expQ.size() == 0) begin
        failCnt++;
        $display("FAIL R11: unexpected read data actual=%h expected=none", regRdData);
      end else begin
        logic [63:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdData !== e) begin
          failCnt++;
          $display("FAIL %s: actual=%h expected=%h", t, regRdData, e);
        end
      end
    end
  end

  task automatic regWrite(input logic [3:0] a, input logic [31:0] v, input logic [31:0] junk);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = a;
    regWrData = {v, junk};
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  task automatic regRead(input logic [3:0] a, input logic [31:0] exp32, input string tag);
    @(negedge clk);
    regRdEn = 1'b1;
    regAddr = a;
    expQ.push_back({exp32, 32'h0});
    tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m, input int n);
    @(negedge clk);
    evtStrobe = m;
    repeat (n) @(negedge clk);
    evtStrobe = '0;
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    @(negedge clk);
    checkCnt++;
    if (irq !== exp) begin
      failCnt++;
      $display("FAIL %s: irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (TIMEOUT_CYC) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkIrq(1'b0, "R1");
    regRead(4'd0, 32'h0, "R1");
    regRead(4'd1, 32'h0, "R1");
    regRead(4'd8, 32'h0, "R1");
    regRead(4'd15, 32'h0, "R1");

    // R2 / R10: write lands in latch, low bus half ignored
    regWrite(4'd8, 32'h1122_3344, 32'hDEAD_BEEF);
    regRead(4'd8, 32'h1122_3344, "R2");

    // R3 commit, R4 counting
    regWrite(4'd0, 32'h8000_0000, 32'hFFFF_FFFF);
    pulse(8'h01, 5);
    regRead(4'd8, 32'h1122_3349, "R3");
    pulse(8'h10, 3);
    regRead(4'd8, 32'h1122_3349, "R4");
    regRead(4'd12, 32'h1122_3349, "R5");

    // R4: no counting while enable clear
    regWrite(4'd0, 32'h0, 32'h0);
    pulse(8'h01, 3);
    regRead(4'd8, 32'h1122_3349, "R4");
    regWrite(4'd0, 32'h8000_0000, 32'h0);
    pulse(8'h01, 1);
    regRead(4'd8, 32'h1122_334A, "R4");

    // R4: 32-bit carry across bit 15
    regWrite(4'd9, 32'h0000_FFFF, 32'h0);
    regWrite(4'd0, 32'h8000_0000, 32'h0);
    pulse(8'h02, 1);
    regRead(4'd9, 32'h0001_0000, "R4");

    // R2 hold while pending, R3 rewrite with enable already set
    regWrite(4'd8, 32'h0000_0100, 32'h0);
    pulse(8'h01, 4);
    regRead(4'd8, 32'h0000_0100, "R2");
    regWrite(4'd0, 32'h8000_0000, 32'h0);
    pulse(8'h01, 2);
    regRead(4'd8, 32'h0000_0102, "R3");

    // R11 map and unimplemented control bits
    regWrite(4'd0, 32'h8000_00F4, 32'h0);
    regRead(4'd0, 32'h8000_0004, "R11");
    regRead(4'd2, 32'h0, "R11");
    regRead(4'd7, 32'h0, "R11");

    // R6 split-mode half writes
    regWrite(4'd10, 32'hABCD_FFFE, 32'h0);
    regWrite(4'd14, 32'h1234_FFFF, 32'h0);
    regRead(4'd10, 32'h0000_FFFE, "R6");
    regRead(4'd14, 32'h0000_FFFF, "R6");
    regWrite(4'd0, 32'h8000_0004, 32'h0);

    // R7 / R9: lower half wraps alone
    regWrite(4'd1, 32'h0000_0040, 32'h0);
    pulse(8'h40, 1);
    checkIrq(1'b1, "R9");
    regRead(4'd14, 32'h0, "R7");
    regRead(4'd10, 32'h0000_FFFE, "R7");
    pulse(8'h04, 2);
    regRead(4'd10, 32'h0, "R7");
    regRead(4'd14, 32'h0, "R7");

    // R8 read-and-clear
    regRead(4'd1, 32'h0000_0044, "R8");
    checkIrq(1'b0, "R8");
    regRead(4'd1, 32'h0, "R8");

    // R9 masked-out flag
    regWrite(4'd1, 32'h0000_0004, 32'h0);
    regWrite(4'd14, 32'h0000_FFFF, 32'h0);
    regWrite(4'd0, 32'h8000_0004, 32'h0);
    pulse(8'h40, 1);
    checkIrq(1'b0, "R9");
    regRead(4'd1, 32'h0000_0040, "R9");

    // R8 32-bit wrap flag, R9 zero mask
    regWrite(4'd11, 32'hFFFF_FFFF, 32'h0);
    regWrite(4'd0, 32'h8000_0004, 32'h0);
    regWrite(4'd1, 32'h0000_0008, 32'h0);
    pulse(8'h08, 1);
    checkIrq(1'b1, "R8");
    regRead(4'd11, 32'h0, "R8");
    regWrite(4'd1, 32'h0, 32'h0);
    checkIrq(1'b0, "R9");
    regRead(4'd1, 32'h0000_0008, "R8");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R11: missing reads actual=%0d pending expected=0", expQ.size());
    end
    finishRun();
  end
endmodule